// File: doc/BRIEF.md
# Toggle-Flag Word Crossing Between Clock Domains

This block moves one multi-bit word at a time from a source clock domain to a destination clock domain whose clock has no fixed relation to the source clock. When the sender strobes a word while the block is ready, the word is latched into a holding register on the source side. The source then announces it by inverting a request level.

The destination sees the request through a flop chain, copies the holding register, raises a one-cycle valid pulse and inverts its own acknowledge level. The acknowledge returns to the source through a second flop chain. The source reports ready again only once the returned acknowledge equals its request level.

Only one word is ever in flight. Because the holding register cannot change while a word is outstanding, the destination may sample it without a synchronizer. Sending faster than the round trip allows is prevented by the ready output, and strobes given while not ready are dropped.

Top module: `toggle_cdc_xfer`

## Requirements
- R1: After both resets are released, `src_ready` is 1 and `dst_valid` is 0, and no word is delivered until one is sent.
- R2: A `src_send` strobe sampled while `src_ready` is 1 accepts `src_data`, and `src_ready` is 0 in the next source cycle.
- R3: A `src_send` strobe sampled while `src_ready` is 0 is ignored: no extra word is delivered and the outstanding word is not altered.
- R4: Every accepted word appears exactly once on `dst_data`, qualified by `dst_valid`.
- R5: Words are delivered in the order they were accepted.
- R6: After an accept, `src_ready` stays 0 for at least the two following source cycles and until the acknowledge has returned. The held word stays unchanged during that time.
- R7: Transfers are correct whether the destination clock is slower or faster than the source clock.
- R8: `dst_valid` is never high in two consecutive destination cycles. When it is high, the acknowledge level already matches the synchronized request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Source domain clock |
| src_rst_n | input | 1 | Source domain synchronous reset, active low |
| src_data | input | DATA_W | Word to send |
| src_send | input | 1 | Send strobe, accepted only while ready |
| src_ready | output | 1 | High when no word is outstanding |
| dst_clk | input | 1 | Destination domain clock |
| dst_rst_n | input | 1 | Destination domain synchronous reset, active low |
| dst_data | output | DATA_W | Delivered word, valid with dst_valid |
| dst_valid | output | 1 | One-cycle pulse per delivered word |

## Verification
The bench builds the block with a 16-bit word and three-stage synchronizers. A wide word makes any mix of old and new bits visible in the compared data. The extra stage stretches the round trip, which widens the window in which ignored strobes can be tried.

Random words are driven through three destination clock rates: slower than, faster than, and close to the source rate. This covers both directions of the clock ratio and phase drift between the clocks. Back-to-back sends and strobes given while not ready exercise back-pressure.

// File: rtl/tcx_pkg.sv
// Shared types for the toggle-flag word crossing.
// Assumes nothing beyond a standard elaboration order (compiled first).
package tcx_pkg;

    // Destination side control state.
    typedef enum logic {
        DST_WAIT = 1'b0,   // waiting for the request level to differ
        DST_TAKE = 1'b1    // copying the held word and flipping acknowledge
    } tcx_dst_state_e;

endpackage

// File: rtl/tcx_sync.sv
// Multi-stage flip-flop synchronizer for one level signal.
// Assumes the input is a slowly changing level (a toggle flag), never a pulse,
// and STAGES >= 2. Reset is synchronous, active low, to RST_VAL.
module tcx_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);

    logic [STAGES-1:0] chain;

    // Shift the asynchronous level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[STAGES-2:0], d_async};
    end

    assign q_sync = chain[STAGES-1];

endmodule

// File: rtl/tcx_src.sv
// Source side: accepts a word while idle, holds it, and inverts the request
// level. Ready is derived from the synchronized acknowledge level.
// Assumes the acknowledge level is reset to the same value as the request.
module tcx_src #(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_send,
    output logic              in_ready,
    input  logic              ack_async,
    output logic              req_flag,
    output logic [DATA_W-1:0] held_data
);

    logic ack_seen;
    logic take;

    tcx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) ack_sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (ack_async),
        .q_sync  (ack_seen)
    );

    assign in_ready = (ack_seen == req_flag);
    assign take     = in_send && in_ready;

    // Flip the request level on each accepted word.
    always_ff @(posedge clk) begin
        if (!rst_n)    req_flag <= 1'b0;
        else if (take) req_flag <= ~req_flag;
    end

    // Capture the word on accept; hold it until the next accept.
    always_ff @(posedge clk) begin
        if (!rst_n)    held_data <= '0;
        else if (take) held_data <= in_data;
    end

    // R2: an accepted word makes the source busy in the next cycle.
    p_busy_after_take_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_send && in_ready) |=> !in_ready);

    // R6: the held word does not move while a word is outstanding.
    p_hold_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |=> $stable(held_data));

    // R3: a strobe while busy leaves the request level alone.
    p_ignore_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_send && !in_ready) |=> $stable(req_flag));

endmodule

// File: rtl/tcx_dst.sv
// Destination side: detects a request level that differs from its local
// acknowledge copy, then copies the held word, pulses valid and flips the copy.
// Assumes the held word is stable from the request flip until the acknowledge
// returns to the source, so it is sampled without a synchronizer.
module tcx_dst
    import tcx_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_async,
    input  logic [DATA_W-1:0] held_data,
    output logic              ack_flag,
    output logic [DATA_W-1:0] out_data,
    output logic              out_valid
);

    logic           req_seen;
    tcx_dst_state_e state;

    tcx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) req_sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (req_async),
        .q_sync  (req_seen)
    );

    // Control: wait for a difference, then take the word for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= DST_WAIT;
        end else begin
            case (state)
                DST_WAIT: if (req_seen != ack_flag) state <= DST_TAKE;
                DST_TAKE: state <= DST_WAIT;
                default:  state <= DST_WAIT;
            endcase
        end
    end

    // Flip the acknowledge copy while the word is taken.
    always_ff @(posedge clk) begin
        if (!rst_n)                 ack_flag <= 1'b0;
        else if (state == DST_TAKE) ack_flag <= ~ack_flag;
    end

    // Register the delivered word and its one-cycle valid pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_data  <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= (state == DST_TAKE);
            if (state == DST_TAKE) out_data <= held_data;
        end
    end

    // R8: valid is a single-cycle pulse.
    p_valid_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    // R8: at delivery the acknowledge already matches the seen request.
    p_ack_matches_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (ack_flag == req_seen));

    // R4: the acknowledge copy only moves when a word is delivered.
    p_ack_moves_with_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_flag != $past(ack_flag)) |-> out_valid);

endmodule

// File: rtl/toggle_cdc_xfer.sv
// Top: one-word crossing between unrelated clocks using toggled request and
// acknowledge levels. Assumes each side's reset is held for at least
// SYNC_STAGES cycles of its own clock, and both are released before use.
module toggle_cdc_xfer #(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              src_clk,
    input  logic              src_rst_n,
    input  logic [DATA_W-1:0] src_data,
    input  logic              src_send,
    output logic              src_ready,
    input  logic              dst_clk,
    input  logic              dst_rst_n,
    output logic [DATA_W-1:0] dst_data,
    output logic              dst_valid
);

    logic              req_lvl;
    logic              ack_lvl;
    logic [DATA_W-1:0] held_word;

    tcx_src #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) src_i (
        .clk       (src_clk),
        .rst_n     (src_rst_n),
        .in_data   (src_data),
        .in_send   (src_send),
        .in_ready  (src_ready),
        .ack_async (ack_lvl),
        .req_flag  (req_lvl),
        .held_data (held_word)
    );

    tcx_dst #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) dst_i (
        .clk       (dst_clk),
        .rst_n     (dst_rst_n),
        .req_async (req_lvl),
        .held_data (held_word),
        .ack_flag  (ack_lvl),
        .out_data  (dst_data),
        .out_valid (dst_valid)
    );

endmodule

// File: tb/toggle_cdc_xfer_tb_top.sv
`timescale 1ns/1ps
module toggle_cdc_xfer_tb_top;

    localparam int DW = 16;
    localparam int SS = 3;

    logic          src_clk = 1'b0;
    logic          dst_clk = 1'b0;
    logic          src_rst_n = 1'b0;
    logic          dst_rst_n = 1'b0;
    logic [DW-1:0] src_data = '0;
    logic          src_send = 1'b0;
    logic          src_ready;
    logic [DW-1:0] dst_data;
    logic          dst_valid;

    real dst_half = 5.0;
    int  total = 0;
    int  bad = 0;
    int  accepted = 0;
    int  delivered = 0;
    logic [DW-1:0] exp_q[$];

    toggle_cdc_xfer #(.DATA_W(DW), .SYNC_STAGES(SS)) dut_i (
        .src_clk   (src_clk),
        .src_rst_n (src_rst_n),
        .src_data  (src_data),
        .src_send  (src_send),
        .src_ready (src_ready),
        .dst_clk   (dst_clk),
        .dst_rst_n (dst_rst_n),
        .dst_data  (dst_data),
        .dst_valid (dst_valid)
    );

    always #2 src_clk = ~src_clk;              // 250 MHz source clock
    always #(dst_half) dst_clk = ~dst_clk;     // variable destination clock

    task automatic check(input bit ok, input string req, input string what,
                         input logic [DW-1:0] act, input logic [DW-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard on each valid pulse (R4, R5, R8).
    logic prev_valid = 1'b0;
    always @(negedge dst_clk) begin
        if (dst_rst_n) begin
            if (dst_valid) begin
                delivered++;
                check(!prev_valid, "R8", "valid two cycles", 1, 0);
                if (exp_q.size() == 0) begin
                    check(0, "R3", "word with none expected", dst_data, 0);
                end else begin
                    automatic logic [DW-1:0] e = exp_q.pop_front();
                    check(dst_data == e, "R5", "word order/data", dst_data, e);
                end
            end
            prev_valid <= dst_valid;
        end
    end

    // Driver: wait for ready, send one word, optionally strobe while busy.
    task automatic send_word(input logic [DW-1:0] d, input bit try_busy);
        while (!src_ready) @(negedge src_clk);
        src_data = d;
        src_send = 1'b1;
        @(negedge src_clk);
        exp_q.push_back(d);
        accepted++;
        check(src_ready == 1'b0, "R2", "ready after accept", src_ready, 0);
        if (try_busy) src_data = ~d;   // ignored strobe, R3
        else          src_send = 1'b0;
        @(negedge src_clk);
        check(src_ready == 1'b0, "R6", "ready early", src_ready, 0);
        src_send = 1'b0;
    endtask

    task automatic drain(input string req);
        int n = 0;
        while (exp_q.size() != 0 && n < 2000) begin
            @(negedge src_clk);
            n++;
        end
        repeat (40) @(negedge src_clk);
        check(exp_q.size() == 0, req, "words left", exp_q.size(), 0);
        check(delivered == accepted, "R4", "delivered count", delivered, accepted);
        check(src_ready == 1'b1, "R6", "ready after return", src_ready, 1);
    endtask

    initial begin
        repeat (6) @(negedge dst_clk);
        src_rst_n = 1'b1;
        dst_rst_n = 1'b1;
        @(negedge src_clk);
        check(src_ready == 1'b1, "R1", "ready at reset", src_ready, 1);
        check(dst_valid == 1'b0, "R1", "valid at reset", dst_valid, 0);
        repeat (30) @(negedge src_clk);
        check(delivered == 0, "R1", "spurious word", delivered, 0);

        // Slow destination (R7).
        for (int i = 0; i < 40; i++) send_word(DW'($urandom), 1'b0);
        drain("R7");

        // Fast destination (R7) with ignored strobes (R3).
        dst_half = 1.3;
        for (int i = 0; i < 40; i++) send_word(DW'($urandom), i[0]);
        drain("R3");

        // Near-equal rates with drifting phase, busy strobes on every word.
        dst_half = 2.07;
        for (int i = 0; i < 40; i++) send_word(DW'($urandom), 1'b1);
        drain("R5");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #100000;
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule